// File: doc/BRIEF.md
# Lock and Fuse Access Unit

This block holds the configuration bytes that a processor core may inspect at run time: one lock byte, three fuse bytes (low, high and extended) and a 32-byte factory signature row. Software reaches them through a timed two-step protocol. It first writes a control value that arms the unit for either configuration access or signature access. It then issues a program-memory read strobe or a store strobe within a short window. A read strobe that arrives while the unit is not armed is passed through, and the unit returns the byte from the normal program memory.

All values are returned raw: a 0 bit means programmed. The lock byte is the only byte that software can change. Its boot-lock field can only move from 1 to 0, and a chip-erase input is the only way back to all ones. Fuse values and the signature contents are fixed per instance by parameters.

Top module: `fuse_lock_unit`

## Requirements
- R1: After a synchronous reset, `rd_valid` is 0, `rd_data` is 0, the unit is not armed, and the lock byte holds `LOCK_INIT | 8'hC3` (8'hFF by default).
- R2: A cycle with `ctl_we` high arms the unit from `ctl_wdata`, where bit 0 is the enable, bit 3 selects configuration access and bit 5 selects signature access. Exactly 8'h09 (enable plus configuration) arms configuration access. Exactly 8'h21 (enable plus signature) arms signature access. Any other combination of these three bits leaves the unit unarmed.
- R3: A strobe is served in armed mode only in the `WINDOW` (4) cycles that follow the `ctl_we` cycle. A strobe in the same cycle as `ctl_we` sees the state from before that write. Once the window has passed, a read strobe returns `pm_rdata`.
- R4: Any strobe taken while the unit is armed ends the arming, so the next read strobe falls back to `pm_rdata`.
- R5: With configuration access armed, a read returns a byte chosen by `addr[1:0]`: 0 gives the low fuse, 1 the lock byte, 2 the extended fuse and 3 the high fuse. The upper address bits are ignored.
- R6: With signature access armed, a read returns signature byte `addr[4:0]`, taken from bits `[8*i+7:8*i]` of `SIG_ROW`.
- R7: `rd_data` and `rd_valid` are updated one cycle after `rd_stb`. `rd_valid` is high only in that cycle.
- R8: A store strobe with configuration access armed sets the lock byte to `old & (st_data | 8'hC3)`. Bits 7, 6, 1 and 0 stay 1, and `addr` has no effect.
- R9: A store can never turn a lock bit from 0 back to 1.
- R10: A store strobe while the unit is unarmed, armed for signature access, or past its window leaves the lock byte unchanged.
- R11: `chip_erase` sets the lock byte to 8'hFF on the next cycle and wins over a store strobe in the same cycle.
- R12: The fuse bytes read back exactly as given by `FUSE_LO`, `FUSE_HI` and `FUSE_EXT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control write strobe (arms the unit) |
| ctl_wdata | input | 8 | Control value: bit 0 enable, bit 3 configuration select, bit 5 signature select |
| rd_stb | input | 1 | Program-memory read strobe |
| st_stb | input | 1 | Store strobe |
| addr | input | ADDR_W | Byte address for the strobe |
| st_data | input | 8 | Data operand for a store |
| pm_rdata | input | 8 | Byte from the normal program memory, used when not armed |
| chip_erase | input | 1 | Restores the lock byte to all ones |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` |

## Verification
The collision of interest is a chip erase that lands in the same cycle as an armed lock store that would clear every writable bit. The bench arms configuration access and raises `chip_erase`, `st_stb` and an all-zero `st_data` on a single clock edge. It then re-arms and reads address 1, and expects 8'hFF. A second case of the same kind raises `ctl_we` and `rd_stb` together, and expects the read to be served from the state in place before that write.

// File: rtl/lfu_pkg.sv
package lfu_pkg;
  localparam int DATA_W      = 8;
  localparam int SIG_MAX     = 32;
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_CFG_BIT = 3;
  localparam int CTL_SIG_BIT = 5;
  // bits of the lock byte that software can never change
  localparam logic [DATA_W-1:0] LOCK_FIXED = 8'hC3;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_CFG  = 2'd1,
    ACC_SIG  = 2'd2
  } acc_mode_e;

  function automatic logic [8*SIG_MAX-1:0] sig_default();
    logic [8*SIG_MAX-1:0] r;
    for (int i = 0; i < SIG_MAX; i++) r[i*8 +: 8] = 8'h1E ^ 8'(i * 11);
    return r;
  endfunction
endpackage

// File: rtl/lfu_arm.sv
module lfu_arm
  import lfu_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [DATA_W-1:0] ctl_wdata,
  input  logic              strobe,
  output acc_mode_e         mode_o
);
  localparam int CNT_W = $clog2(WINDOW + 1);

  acc_mode_e        mode_q, dec;
  logic [CNT_W-1:0] cnt_q;
  logic             en, cfg, sig;
  logic             unused_ctl;

  assign en  = ctl_wdata[CTL_EN_BIT];
  assign cfg = ctl_wdata[CTL_CFG_BIT];
  assign sig = ctl_wdata[CTL_SIG_BIT];
  assign unused_ctl = ^ctl_wdata;

  always_comb begin
    if (en && cfg && !sig)      dec = ACC_CFG;
    else if (en && sig && !cfg) dec = ACC_SIG;
    else                        dec = ACC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= ACC_NONE;
      cnt_q  <= '0;
    end else if (ctl_we) begin
      mode_q <= dec;
      cnt_q  <= (dec == ACC_NONE) ? '0 : CNT_W'(WINDOW);
    end else if (mode_q != ACC_NONE && (strobe || cnt_q == CNT_W'(1))) begin
      mode_q <= ACC_NONE;
      cnt_q  <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign mode_o = mode_q;

  // R3: an armed unit always has a live window count
  p_armed_count_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_q != ACC_NONE) |-> (cnt_q != '0 && cnt_q <= CNT_W'(WINDOW)));
  // R3: last window cycle without a new write disarms
  p_expire_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_q != ACC_NONE && cnt_q == CNT_W'(1) && !ctl_we) |=> (mode_q == ACC_NONE));
  // R4: a strobe consumes the arming
  p_consume_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q != ACC_NONE && strobe && !ctl_we) |=> (mode_q == ACC_NONE));
endmodule

// File: rtl/lfu_lock_reg.sv
module lfu_lock_reg
  import lfu_pkg::*;
#(
  parameter logic [DATA_W-1:0] LOCK_INIT = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              erase,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] lock_o
);
  logic [DATA_W-1:0] lock_q;

  always_ff @(posedge clk) begin
    if (rst)        lock_q <= LOCK_INIT | LOCK_FIXED;
    else if (erase) lock_q <= '1;
    else if (wr_en) lock_q <= lock_q & (wr_data | LOCK_FIXED);
  end

  assign lock_o = lock_q;

  // R9: without erase no bit ever rises
  p_one_way_r9: assert property (@(posedge clk) disable iff (rst)
    !erase |=> ((lock_q & ~$past(lock_q)) == '0));
  // R11: erase restores all ones
  p_erase_r11: assert property (@(posedge clk) disable iff (rst)
    erase |=> (lock_q == '1));
  // R8: fixed bits stay at one
  p_fixed_bits_r8: assert property (@(posedge clk) disable iff (rst)
    ((lock_q & LOCK_FIXED) == LOCK_FIXED));
endmodule

// File: rtl/lfu_sig_rom.sv
module lfu_sig_rom
  import lfu_pkg::*;
#(
  parameter int                     DEPTH = 32,
  parameter logic [8*DEPTH-1:0]     ROW   = '0,
  localparam int                    AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    assign rom[i] = ROW[i*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rd_en) q <= rom[addr];
  end
endmodule

// File: rtl/fuse_lock_unit.sv
module fuse_lock_unit
  import lfu_pkg::*;
#(
  parameter int                     ADDR_W    = 16,
  parameter int                     WINDOW    = 4,
  parameter int                     SIG_DEPTH = SIG_MAX,
  parameter logic [7:0]             FUSE_LO   = 8'h62,
  parameter logic [7:0]             FUSE_HI   = 8'hD9,
  parameter logic [7:0]             FUSE_EXT  = 8'hFF,
  parameter logic [7:0]             LOCK_INIT = 8'hFF,
  parameter logic [8*SIG_DEPTH-1:0] SIG_ROW   = sig_default()
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  input  logic              rd_stb,
  input  logic              st_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        st_data,
  input  logic [7:0]        pm_rdata,
  input  logic              chip_erase,
  output logic [7:0]        rd_data,
  output logic              rd_valid
);
  localparam int SIG_AW = $clog2(SIG_DEPTH);

  acc_mode_e   mode;
  logic [7:0]  lock_q, cfg_byte, sig_q, oth_q;
  logic        from_sig_q;
  logic        unused_addr;

  assign unused_addr = ^addr[ADDR_W-1:SIG_AW];

  lfu_arm #(.WINDOW(WINDOW)) u_arm (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .strobe(rd_stb | st_stb), .mode_o(mode)
  );

  lfu_lock_reg #(.LOCK_INIT(LOCK_INIT)) u_lock (
    .clk(clk), .rst(rst), .erase(chip_erase),
    .wr_en(st_stb && mode == ACC_CFG), .wr_data(st_data), .lock_o(lock_q)
  );

  lfu_sig_rom #(.DEPTH(SIG_DEPTH), .ROW(SIG_ROW)) u_sig (
    .clk(clk), .rd_en(rd_stb && mode == ACC_SIG),
    .addr(addr[SIG_AW-1:0]), .q(sig_q)
  );

  always_comb begin
    unique case (addr[1:0])
      2'd0:    cfg_byte = FUSE_LO;
      2'd1:    cfg_byte = lock_q;
      2'd2:    cfg_byte = FUSE_EXT;
      default: cfg_byte = FUSE_HI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      oth_q      <= '0;
      from_sig_q <= 1'b0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) begin
        from_sig_q <= (mode == ACC_SIG);
        oth_q      <= (mode == ACC_CFG) ? cfg_byte : pm_rdata;
      end
    end
  end

  assign rd_data = from_sig_q ? sig_q : oth_q;

  // R7: valid pulse follows the strobe by one cycle
  p_valid_hi_r7: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rd_valid);
  p_valid_lo_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> !rd_valid);
  // R3: unarmed read passes program memory through
  p_fallback_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && mode == ACC_NONE) |=> (rd_data == $past(pm_rdata)));
  // R5: lock byte readable at index 1
  p_lock_read_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && mode == ACC_CFG && addr[1:0] == 2'd1) |=> (rd_data == $past(lock_q)));
  // R10: stores outside configuration arming leave the lock byte alone
  p_store_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (st_stb && mode != ACC_CFG && !chip_erase) |=> $stable(lock_q));
endmodule

// File: tb/test_fuse_lock_unit.sv
module test_fuse_lock_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] F_LO = 8'hE2, F_HI = 8'hD9, F_EXT = 8'hFD;

  function automatic logic [7:0] sig_byte(input int i);
    return 8'(i * 29 + 7) ^ 8'h5A;
  endfunction
  function automatic logic [255:0] bench_sig();
    logic [255:0] r;
    for (int i = 0; i < 32; i++) r[i*8 +: 8] = sig_byte(i);
    return r;
  endfunction
  function automatic logic [7:0] pm_of(input logic [15:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0, rd_stb = 1'b0, st_stb = 1'b0, chip_erase = 1'b0;
  logic [7:0]  ctl_wdata = '0, st_data = '0;
  logic [15:0] addr = '0;
  logic [7:0]  pm_rdata, rd_data;
  logic        rd_valid;
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  assign pm_rdata = pm_of(addr);
  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_lock_unit #(
    .FUSE_LO(F_LO), .FUSE_HI(F_HI), .FUSE_EXT(F_EXT), .SIG_ROW(bench_sig())
  ) i_fuse_lock_unit (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .rd_stb(rd_stb), .st_stb(st_stb), .addr(addr), .st_data(st_data),
    .pm_rdata(pm_rdata), .chip_erase(chip_erase),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic idle(input int n); repeat (n) tick(); endtask
  task automatic arm(input logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v; tick(); ctl_we = 1'b0; ctl_wdata = '0;
  endtask
  task automatic rd(input logic [15:0] a, output logic [7:0] d, output logic v);
    rd_stb = 1'b1; addr = a; tick(); rd_stb = 1'b0; d = rd_data; v = rd_valid;
  endtask
  task automatic st(input logic [7:0] dat, input logic [15:0] a);
    st_stb = 1'b1; st_data = dat; addr = a; tick(); st_stb = 1'b0;
  endtask
  task automatic erase();
    chip_erase = 1'b1; tick(); chip_erase = 1'b0;
  endtask
  task automatic read_lock(output logic [7:0] d);
    logic v;
    arm(8'h09); rd(16'h0001, d, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, m, exp;
    logic       v;
    idle(3); rst = 1'b0;
    // R1 reset state
    chk("R1 rd_valid", {7'b0, rd_valid}, 8'h00);
    chk("R1 rd_data", rd_data, 8'h00);
    rd(16'h0000, d, v); chk("R1 unarmed", d, pm_of(16'h0000));
    read_lock(d); chk("R1 lock init", d, 8'hFF);

    // R5 R12 table map with upper address bits
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 4; j++) begin
        logic [15:0] a;
        a = 16'({j == 0 ? 0 : j == 1 ? 1 : j == 2 ? 16'h3F : 16'hFFF} * 4 + k);
        case (k)
          0: exp = F_LO; 1: exp = 8'hFF; 2: exp = F_EXT; default: exp = F_HI;
        endcase
        arm(8'h09); rd(a, d, v);
        chk("R5 R12 cfg map", d, exp);
        chk("R7 valid", {7'b0, v}, 8'h01);
      end
    end
    tick(); chk("R7 valid drops", {7'b0, rd_valid}, 8'h00);

    // R6 signature sweep
    for (int i = 0; i < 32; i++) begin
      arm(8'h21); rd(16'(i) | 16'((i % 3) << 8), d, v);
      chk("R6 signature", d, sig_byte(i));
    end

    // R3 window sweep, both modes
    for (int dly = 0; dly < 6; dly++) begin
      arm(8'h09); idle(dly); rd(16'h0000, d, v);
      chk("R3 cfg window", d, (dly <= 3) ? F_LO : pm_of(16'h0000));
      arm(8'h21); idle(dly); rd(16'h0003, d, v);
      chk("R3 sig window", d, (dly <= 3) ? sig_byte(3) : pm_of(16'h0003));
    end

    // R2 arming code sweep
    for (int c = 0; c < 8; c++) begin
      logic [7:0] cv;
      cv = {2'b0, c[2], 1'b0, c[1], 2'b0, c[0]};
      arm(cv); rd(16'h0000, d, v);
      exp = (cv == 8'h09) ? F_LO : (cv == 8'h21) ? sig_byte(0) : pm_of(16'h0000);
      chk("R2 arm code", d, exp);
    end

    // R4 consumption
    arm(8'h09); rd(16'h0002, d, v); chk("R4 first", d, F_EXT);
    rd(16'h0002, d, v); chk("R4 second falls back", d, pm_of(16'h0002));

    // R3 strobe in the arming cycle sees old state
    ctl_we = 1'b1; ctl_wdata = 8'h09; rd_stb = 1'b1; addr = 16'h0000; tick();
    ctl_we = 1'b0; rd_stb = 1'b0;
    chk("R3 same-cycle strobe", rd_data, pm_of(16'h0000));
    rd(16'h0000, d, v); chk("R3 armed after", d, F_LO);

    // R8 exhaustive store data
    for (int dv = 0; dv < 256; dv++) begin
      erase(); arm(8'h09); st(8'(dv), 16'(dv * 257));
      read_lock(d); chk("R8 store", d, 8'(dv) | 8'hC3);
    end

    // R9 cumulative one-way
    erase(); m = 8'hFF;
    for (int s = 0; s < 6; s++) begin
      logic [7:0] sv;
      sv = 8'(8'hF7 ^ (s * 8'h24));
      arm(8'h09); st(sv, 16'h0000); m = m & (sv | 8'hC3);
      read_lock(d); chk("R9 one-way", d, m);
    end

    // R10 ignored stores
    erase(); arm(8'h21); st(8'h00, 16'h0001);
    read_lock(d); chk("R10 sig-armed store", d, 8'hFF);
    st(8'h00, 16'h0001); read_lock(d); chk("R10 unarmed store", d, 8'hFF);
    arm(8'h09); idle(4); st(8'h00, 16'h0001);
    read_lock(d); chk("R10 expired store", d, 8'hFF);
    arm(8'h21); st(8'h00, 16'h0000); rd(16'h0000, d, v);
    chk("R10 R4 store consumes", d, pm_of(16'h0000));

    // R11 erase
    arm(8'h09); st(8'h00, 16'h0000); read_lock(d); chk("R11 programmed", d, 8'hC3);
    erase(); read_lock(d); chk("R11 erase", d, 8'hFF);
    arm(8'h09);
    chip_erase = 1'b1; st_stb = 1'b1; st_data = 8'h00; tick();
    chip_erase = 1'b0; st_stb = 1'b0;
    read_lock(d); chk("R11 erase beats store", d, 8'hFF);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule